// File: doc/BRIEF.md
# Pipeline Exception and Flush Controller

This block is the exception and hazard control for a five-stage in-order pipeline. It watches two exception sources: an arithmetic overflow reported by the EX stage, and an undefined instruction reported by the ID stage. When either is flagged, it squashes the younger instructions in the same cycle. The IF/ID latch captures an all-zeros nop word in place of the fetched instruction. The instruction in ID keeps its word but has its control bits cleared. For an overflow, the faulting EX instruction also loses its register write. In that same cycle the block steers the next-PC mux to a fixed handler address. On the following clock edge it records the resume address and a cause code.

The block also makes the one-cycle bubble that follows a branch-equal in ID. That bubble is an all-zeros word written into IF/ID, not a clearing of ID control bits. This keeps it distinct from the control-zeroing used for load-use stalls and exception squashes. The datapath, ALU and register file sit outside this block. They consume its control outputs.

Top module: `exc_ctrl`

## Requirements
- R1: A synchronous active-high reset clears `epc` and `cause` to zero. While `rst` is high, `pc_sel_handler`, `if_nop` and `id_kill` are 0.
- R2: When `ex_ovf` is 1 (and `rst` is 0), all of the following hold combinationally in that same cycle: `if_nop`=1, `id_kill`=1, `pc_sel_handler`=1 and `ex_regwrite_out`=0.
- R3: When `id_undef` is 1 and `ex_ovf` is 0, the following hold in that cycle: `if_nop`=1, `id_kill`=1 and `pc_sel_handler`=1. `ex_regwrite_out` follows `ex_regwrite_in`, because the older EX instruction completes.
- R4: After the clock edge that ends a cycle with an exception, `epc` holds the faulting instruction's PC plus 4. For an overflow this is `ex_pc`+4; for an undefined instruction it is `id_pc`+4.
- R5: After an exception, `cause` holds the code in bits [6:2], with every other bit zero. The code is 12 for overflow and 10 for undefined instruction.
- R6: `handler_pc` is the constant 32'h8000_0180. Because `pc_sel_handler` is 1 in the detection cycle, the PC holds this address in the next cycle.
- R7: If `ex_ovf` and `id_undef` are both 1, the overflow wins. `ex_regwrite_out`=0, `epc`=`ex_pc`+4, and the cause code is 12.
- R8: When `id_is_beq` is 1 and there is no exception, `if_nop`=1, `id_kill`=0 and `pc_sel_handler`=0.
- R9: In cycles with no exception, `epc` and `cause` keep their values.
- R10: With no overflow, `ex_regwrite_out` equals `ex_regwrite_in`. With no exception and no branch, `if_nop`, `id_kill` and `pc_sel_handler` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_ovf | input | 1 | Arithmetic overflow detected in EX |
| id_undef | input | 1 | Undefined instruction decoded in ID |
| id_is_beq | input | 1 | Branch-equal decoded in ID |
| ex_regwrite_in | input | 1 | Register-write control of the EX instruction |
| id_pc | input | 32 | PC of the ID instruction |
| ex_pc | input | 32 | PC of the EX instruction |
| if_nop | output | 1 | Load an all-zeros word into IF/ID |
| id_kill | output | 1 | Clear control bits of the ID instruction |
| ex_regwrite_out | output | 1 | Gated register-write control for EX |
| pc_sel_handler | output | 1 | Next-PC mux selects the handler address |
| handler_pc | output | 32 | Handler start address |
| epc | output | 32 | Resume address register |
| cause | output | 32 | Cause register |

## Verification
The flush and select outputs are combinational. A wrong priority or a missing gate therefore shows at `if_nop`, `id_kill`, `ex_regwrite_out` or `pc_sel_handler` in the same cycle as the stimulus. A fault in the recorded state shows one edge later: an off-by-four address, the wrong source PC, a misplaced cause field, or a register that fails to hold. The bench runs each scenario, including simultaneous sources and a branch under an exception. It reads `epc` and `cause` in the cycle after the edge, and again after idle cycles to confirm that they hold.

// File: rtl/exc_ctrl.sv
module exc_ctrl #(
  parameter int          XLEN       = 32,
  parameter logic [31:0] HANDLER    = 32'h8000_0180,
  parameter int          CODE_W     = 5,
  parameter int          CODE_LSB   = 2,
  parameter int          OVF_CODE   = 12,
  parameter int          UNDEF_CODE = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ex_ovf,
  input  logic            id_undef,
  input  logic            id_is_beq,
  input  logic            ex_regwrite_in,
  input  logic [XLEN-1:0] id_pc,
  input  logic [XLEN-1:0] ex_pc,
  output logic            if_nop,
  output logic            id_kill,
  output logic            ex_regwrite_out,
  output logic            pc_sel_handler,
  output logic [XLEN-1:0] handler_pc,
  output logic [XLEN-1:0] epc,
  output logic [XLEN-1:0] cause
);

  localparam logic [XLEN-1:0] WORD = XLEN'(4);

  logic            ovf_take, undef_take, take;
  logic [XLEN-1:0] fault_pc;
  logic [XLEN-1:0] cause_next;

  assign ovf_take   = ex_ovf & ~rst;
  assign undef_take = id_undef & ~ex_ovf & ~rst;
  assign take       = ovf_take | undef_take;

  assign if_nop          = take | (id_is_beq & ~rst);
  assign id_kill         = take;
  assign pc_sel_handler  = take;
  assign ex_regwrite_out = ex_regwrite_in & ~ovf_take;
  assign handler_pc      = XLEN'(HANDLER);

  assign fault_pc = ovf_take ? ex_pc : id_pc;

  always_comb begin
    cause_next = '0;
    cause_next[CODE_LSB +: CODE_W] = ovf_take ? CODE_W'(OVF_CODE) : CODE_W'(UNDEF_CODE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      epc   <= '0;
      cause <= '0;
    end else if (take) begin
      epc   <= fault_pc + WORD;
      cause <= cause_next;
    end
  end

  // R2
  ovf_squash_chk: assert property (@(posedge clk) disable iff (rst)
    ex_ovf |-> (if_nop && id_kill && pc_sel_handler && !ex_regwrite_out));

  // R3
  undef_squash_chk: assert property (@(posedge clk) disable iff (rst)
    (id_undef && !ex_ovf) |-> (if_nop && id_kill && pc_sel_handler && ex_regwrite_out == ex_regwrite_in));

  // R4
  epc_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    ex_ovf |=> (epc == $past(ex_pc) + WORD));

  // R4
  epc_undef_chk: assert property (@(posedge clk) disable iff (rst)
    (id_undef && !ex_ovf) |=> (epc == $past(id_pc) + WORD));

  // R8
  beq_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (id_is_beq && !ex_ovf && !id_undef) |-> (if_nop && !id_kill && !pc_sel_handler));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ex_ovf && !id_undef) |=> ($stable(epc) && $stable(cause)));

  // R5
  cause_field_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_ovf || id_undef) |=> ($countones(cause) == 2 || $countones(cause) == 2));

endmodule

// File: tb/test_exc_ctrl.sv
module test_exc_ctrl;
  logic        clk = 0;
  logic        rst;
  logic        ex_ovf, id_undef, id_is_beq, ex_regwrite_in;
  logic [31:0] id_pc, ex_pc;
  logic        if_nop, id_kill, ex_regwrite_out, pc_sel_handler;
  logic [31:0] handler_pc, epc, cause;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  exc_ctrl i_exc_ctrl (
    .clk, .rst, .ex_ovf, .id_undef, .id_is_beq, .ex_regwrite_in,
    .id_pc, .ex_pc, .if_nop, .id_kill, .ex_regwrite_out, .pc_sel_handler,
    .handler_pc, .epc, .cause
  );

  localparam logic [31:0] C_OVF   = 32'd12 << 2;
  localparam logic [31:0] C_UNDEF = 32'd10 << 2;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    ex_ovf = 0; id_undef = 0; id_is_beq = 0; ex_regwrite_in = 1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1; ex_ovf = 1; id_undef = 1; id_is_beq = 1;
    #1;
    chk("R1 sel", {31'd0, pc_sel_handler}, 0);
    chk("R1 nop", {31'd0, if_nop}, 0);
    chk("R1 kill", {31'd0, id_kill}, 0);
    @(negedge clk);
    chk("R1 epc", epc, 0);
    chk("R1 cause", cause, 0);
    rst = 0; idle();
    #1;
    chk("R10 nop", {31'd0, if_nop}, 0);
    chk("R10 kill", {31'd0, id_kill}, 0);
    chk("R10 rw", {31'd0, ex_regwrite_out}, 1);
    chk("R6 vec", handler_pc, 32'h8000_0180);
  endtask

  task automatic t_overflow();
    @(negedge clk);
    ex_ovf = 1; ex_pc = 32'h0040_0010; id_pc = 32'h0040_0014;
    #1;
    chk("R2 nop", {31'd0, if_nop}, 1);
    chk("R2 kill", {31'd0, id_kill}, 1);
    chk("R2 rw", {31'd0, ex_regwrite_out}, 0);
    chk("R2 sel", {31'd0, pc_sel_handler}, 1);
    @(negedge clk);
    idle();
    chk("R4 epc ovf", epc, 32'h0040_0014);
    chk("R5 cause ovf", cause, C_OVF);
  endtask

  task automatic t_hold();
    repeat (3) @(negedge clk);
    chk("R9 epc", epc, 32'h0040_0014);
    chk("R9 cause", cause, C_OVF);
    ex_regwrite_in = 0;
    #1;
    chk("R10 rw low", {31'd0, ex_regwrite_out}, 0);
    ex_regwrite_in = 1;
  endtask

  task automatic t_undef();
    @(negedge clk);
    id_undef = 1; id_pc = 32'h0000_1000; ex_pc = 32'h0000_0ffc;
    #1;
    chk("R3 nop", {31'd0, if_nop}, 1);
    chk("R3 kill", {31'd0, id_kill}, 1);
    chk("R3 rw", {31'd0, ex_regwrite_out}, 1);
    chk("R3 sel", {31'd0, pc_sel_handler}, 1);
    @(negedge clk);
    idle();
    chk("R4 epc undef", epc, 32'h0000_1004);
    chk("R5 cause undef", cause, C_UNDEF);
  endtask

  task automatic t_both();
    @(negedge clk);
    ex_ovf = 1; id_undef = 1; ex_pc = 32'h0000_2000; id_pc = 32'h0000_2004;
    #1;
    chk("R7 rw", {31'd0, ex_regwrite_out}, 0);
    @(negedge clk);
    idle();
    chk("R7 epc", epc, 32'h0000_2004);
    chk("R7 cause", cause, C_OVF);
  endtask

  task automatic t_beq();
    @(negedge clk);
    id_is_beq = 1; id_pc = 32'h0000_3000;
    #1;
    chk("R8 nop", {31'd0, if_nop}, 1);
    chk("R8 kill", {31'd0, id_kill}, 0);
    chk("R8 sel", {31'd0, pc_sel_handler}, 0);
    @(negedge clk);
    chk("R9 epc after beq", epc, 32'h0000_2004);
    id_undef = 1;
    #1;
    chk("R3 beq+undef kill", {31'd0, id_kill}, 1);
    @(negedge clk);
    idle();
    chk("R4 epc beq undef", epc, 32'h0000_3004);
    chk("R5 cause beq undef", cause, C_UNDEF);
  endtask

  initial begin
    rst = 1; idle(); id_pc = 0; ex_pc = 0;
    t_reset();
    t_overflow();
    t_hold();
    t_undef();
    t_both();
    t_beq();
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule